// File: doc/BRIEF.md
# NAND Flash Command and Address Front End

This block is the device-side command interpreter of a small NAND flash memory. On a single system clock it samples an 8-bit data bus together with chip-enable, command-latch, address-latch and write-protect pins. A one-cycle write strobe qualifies each byte. Command bytes select an operation. Address bytes are packed into a 40-bit address, lowest byte first. At the cycle where an operation becomes complete, the block emits a one-cycle start pulse to a separate array engine, together with the assembled address and a column offset.

Two short answers come from the block itself: the identification bytes and the status byte. Both are placed in a four-byte output buffer, and a read strobe walks through that buffer. The page format is fixed at elaboration time. A small-page part has 512-byte pages and three address cycles. A large-page part has 2048-byte pages and needs four address cycles up to 1024 Mbit or five cycles from 2048 Mbit. The format decides where triggers fall, how far the erase address is shifted, and which commands exist.

Top module: `nand_cmd_front`

## Requirements
- R1: After reset every start pulse and `cmd_err` are 0, `op_addr` and `op_col` are 0, and `io_dout` reads 0x00 (empty buffer).
- R2: A byte counts as a command only when `io_we`=1, `ce_n`=0 and `cle`=1. It counts as an address byte only when `io_we`=1, `ce_n`=0, `cle`=0 and `ale`=1, so command latch wins over address latch. A read strobe counts only while `ce_n`=0. A byte outside these conditions changes nothing.
- R3: Command 0x00 sets the column offset to 0, 0x01 sets it to 0x100 and 0x50 sets it to the page size (512 or 2048). After 0x01 and 0x50 the block behaves exactly as after 0x00. The offset appears on `op_col` with the read start pulse.
- R4: Address byte number k (counting from 0) lands in `op_addr[8k+7:8k]`, and `op_addr` always shows the current address. Every accepted command except 0xE0 restarts the count at 0. Bytes after the fifth are dropped.
- R5: After 0x90, the first address byte loads the buffer. Successive reads then return the manufacturer ID (default 0xEC), the device ID (default 0x73), 0xA5, and finally 0xC0 (small page) or 0x15 (large page). After that the output is 0x00.
- R6: After command 0x00, `load_go` pulses in the cycle after address byte 3 (small page), byte 4 (large page, 1024 Mbit or less) or byte 5 (large page, 2048 Mbit or more). After command 0x80, `setup_go` pulses at the same point.
- R7: Command 0x70 loads a status byte with bit 7 = `wp_n`, bit 6 = busy (always 0) and bit 0 = error. Reads keep returning that byte until the next accepted command, after which the output is 0x00.
- R8: Command 0xFF restores command 0x00, clears the address, the address count, the column offset and the buffer, and clears the status error bit.
- R9: Command 0x10 pulses `prog_go` and command 0xD0 pulses `erase_go` one cycle later, but only if `wp_n`=1. If `wp_n`=0 there is no pulse and the status error bit is set; a confirm that is accepted clears the error bit. Command 0xD0 first shifts the address left by 8 bits (small page) or 16 bits (large page).
- R10: On large-page parts, 0x30 has no effect while the current command is 0x00. 0x05 clears address bits 15:0 and restarts the count. 0xE0 keeps the count, pulses `load_go`, and puts address bits 15:0 on `op_col`. On small-page parts, 0x30, 0x05 and 0xE0 are unknown commands.
- R11: An unknown command byte (for example 0x35 or 0x15) leaves all state unchanged and pulses `cmd_err` for one cycle.
- R12: At most one of `load_go`, `setup_go`, `prog_go`, `erase_go` and `cmd_err` is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ce_n | input | 1 | Chip enable, active low |
| cle | input | 1 | Command latch enable |
| ale | input | 1 | Address latch enable |
| wp_n | input | 1 | Write protect, active low |
| io_we | input | 1 | One-cycle strobe qualifying `io_din` |
| io_re | input | 1 | One-cycle read strobe for the output buffer |
| io_din | input | 8 | Bus byte from the host |
| io_dout | output | 8 | Current output-buffer byte |
| load_go | output | 1 | Page/column read start pulse |
| setup_go | output | 1 | Program setup complete pulse |
| prog_go | output | 1 | Program start pulse |
| erase_go | output | 1 | Block erase start pulse |
| cmd_err | output | 1 | Unknown command pulse |
| op_addr | output | 40 | Assembled address |
| op_col | output | 16 | Column offset given with `load_go` |

## Verification
The embedded assertions check four properties on every clock: the start pulses exclude one another, a program or erase start is never issued unless write protect was released in the confirm cycle, a rejected command leaves the command and the address untouched, and a repeated status read keeps its output byte. The address count also stays within its limit. Other behaviour can only be shown by the bench scenarios running against three page formats side by side: where each trigger falls for each format, how the read commands remap the offset, what the identification and status bytes contain, the large-page random-read flow, and how reset clears the error bit.

// File: rtl/nand_seq_pkg.sv
package nand_seq_pkg;

    localparam logic [7:0] OPC_RD0   = 8'h00;
    localparam logic [7:0] OPC_RD1   = 8'h01;
    localparam logic [7:0] OPC_RD2   = 8'h50;
    localparam logic [7:0] OPC_CONF  = 8'h30;
    localparam logic [7:0] OPC_RSEL  = 8'h05;
    localparam logic [7:0] OPC_RGO   = 8'hE0;
    localparam logic [7:0] OPC_ID    = 8'h90;
    localparam logic [7:0] OPC_RST   = 8'hFF;
    localparam logic [7:0] OPC_PSET  = 8'h80;
    localparam logic [7:0] OPC_PGO   = 8'h10;
    localparam logic [7:0] OPC_ESET  = 8'h60;
    localparam logic [7:0] OPC_EGO   = 8'hD0;
    localparam logic [7:0] OPC_STAT  = 8'h70;
    localparam logic [7:0] OPC_COPY  = 8'h85;

    localparam logic [7:0] ID_FILLER = 8'hA5;
    localparam logic [7:0] ID_SMALL  = 8'hC0;
    localparam logic [7:0] ID_LARGE  = 8'h15;

    typedef enum logic [3:0] {
        K_BAD, K_RD0, K_RD1, K_RD2, K_CONF, K_RSEL, K_RGO, K_ID,
        K_RST, K_PSET, K_PGO, K_ESET, K_EGO, K_STAT, K_COPY
    } op_kind_e;

endpackage

// File: rtl/nand_cmd_decode.sv
module nand_cmd_decode
    import nand_seq_pkg::*;
#(
    parameter bit LARGE_PAGE = 1'b0
) (
    input  logic [7:0] opc,
    output op_kind_e   kind
);

    always_comb begin
        case (opc)
            OPC_RD0:  kind = K_RD0;
            OPC_RD1:  kind = K_RD1;
            OPC_RD2:  kind = K_RD2;
            OPC_CONF: kind = LARGE_PAGE ? K_CONF : K_BAD;
            OPC_RSEL: kind = LARGE_PAGE ? K_RSEL : K_BAD;
            OPC_RGO:  kind = LARGE_PAGE ? K_RGO  : K_BAD;
            OPC_ID:   kind = K_ID;
            OPC_RST:  kind = K_RST;
            OPC_PSET: kind = K_PSET;
            OPC_PGO:  kind = K_PGO;
            OPC_ESET: kind = K_ESET;
            OPC_EGO:  kind = K_EGO;
            OPC_STAT: kind = K_STAT;
            OPC_COPY: kind = K_COPY;
            default:  kind = K_BAD;
        endcase
    end

endmodule

// File: rtl/nand_outbuf.sv
module nand_outbuf #(
    parameter int DEPTH = 4
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          ld,
    input  logic                          clr,
    input  logic                          rd,
    input  logic [DEPTH*8-1:0]            ld_data,
    input  logic [$clog2(DEPTH+1)-1:0]    ld_len,
    input  logic                          ld_stick,
    output logic [7:0]                    dout
);

    localparam int LW = $clog2(DEPTH + 1);
    localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    typedef struct packed {
        logic [DEPTH*8-1:0] data;
        logic [LW-1:0]      len;
        logic [LW-1:0]      ptr;
        logic               stick;
    } ob_t;

    ob_t st_q, st_d;
    logic [7:0] byte_v [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        assign byte_v[g] = st_q.data[8*g +: 8];
    end

    always_comb begin
        st_d = st_q;
        if (ld) begin
            st_d.data  = ld_data;
            st_d.len   = ld_len;
            st_d.ptr   = '0;
            st_d.stick = ld_stick;
        end else if (clr) begin
            st_d.len   = '0;
            st_d.ptr   = '0;
            st_d.stick = 1'b0;
        end else if (rd && !st_q.stick && (st_q.ptr < st_q.len)) begin
            st_d.ptr = st_q.ptr + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign dout = (st_q.ptr < st_q.len) ? byte_v[st_q.ptr[IW-1:0]] : 8'h00;

    // R7
    stick_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.stick && rd && !ld && !clr) |=> $stable(dout));

endmodule

// File: rtl/nand_cmd_front.sv
module nand_cmd_front
    import nand_seq_pkg::*;
#(
    parameter bit         LARGE_PAGE   = 1'b0,
    parameter int         DENSITY_MBIT = 128,
    parameter logic [7:0] MFR_ID       = 8'hEC,
    parameter logic [7:0] DEV_ID       = 8'h73,
    parameter int         ADDR_BYTES   = 5
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    ce_n,
    input  logic                    cle,
    input  logic                    ale,
    input  logic                    wp_n,
    input  logic                    io_we,
    input  logic                    io_re,
    input  logic [7:0]              io_din,
    output logic [7:0]              io_dout,
    output logic                    load_go,
    output logic                    setup_go,
    output logic                    prog_go,
    output logic                    erase_go,
    output logic                    cmd_err,
    output logic [8*ADDR_BYTES-1:0] op_addr,
    output logic [15:0]             op_col
);

    localparam int ADDR_W    = 8 * ADDR_BYTES;
    localparam int CNT_W     = $clog2(ADDR_BYTES + 1);
    localparam int OFS_W     = 16;
    localparam int PAGE_BITS = LARGE_PAGE ? 11 : 9;
    localparam int COL_BITS  = LARGE_PAGE ? 16 : 8;
    localparam int TRIG_CYC  = LARGE_PAGE ? ((DENSITY_MBIT >= 2048) ? 5 : 4) : 3;
    localparam int BUF_BYTES = 4;
    localparam int LW        = $clog2(BUF_BYTES + 1);
    localparam logic [7:0]        ID_LAST   = LARGE_PAGE ? ID_LARGE : ID_SMALL;
    localparam logic [OFS_W-1:0]  PAGE_SIZE = OFS_W'(1) << PAGE_BITS;
    localparam logic [ADDR_W-1:0] COL_MASK  = (ADDR_W'(1) << COL_BITS) - ADDR_W'(1);

    typedef struct packed {
        logic [7:0]        cmd;
        logic [ADDR_W-1:0] addr;
        logic [CNT_W-1:0]  cnt;
        logic [OFS_W-1:0]  ofs;
        logic              fail;
        logic [OFS_W-1:0]  col;
        logic              ld;
        logic              su;
        logic              pg;
        logic              er;
        logic              bad;
    } seq_t;

    seq_t st_q, st_d;
    op_kind_e kind;

    logic                   b_ld, b_clr, b_stick;
    logic [BUF_BYTES*8-1:0] b_data;
    logic [LW-1:0]          b_len;
    logic [CNT_W-1:0]       cnt_inc;
    logic                   cmd_cyc, adr_cyc;

    nand_cmd_decode #(.LARGE_PAGE(LARGE_PAGE)) u_dec (
        .opc  (io_din),
        .kind (kind)
    );

    assign cmd_cyc = io_we && !ce_n && cle;
    assign adr_cyc = io_we && !ce_n && !cle && ale;
    assign cnt_inc = st_q.cnt + 1'b1;

    always_comb begin
        st_d     = st_q;
        st_d.ld  = 1'b0;
        st_d.su  = 1'b0;
        st_d.pg  = 1'b0;
        st_d.er  = 1'b0;
        st_d.bad = 1'b0;
        b_ld     = 1'b0;
        b_clr    = 1'b0;
        b_stick  = 1'b0;
        b_data   = '0;
        b_len    = '0;

        if (cmd_cyc) begin
            if (kind == K_BAD) begin
                st_d.bad = 1'b1;
            end else if (kind == K_CONF && st_q.cmd == OPC_RD0) begin
                st_d.cmd = st_q.cmd;
            end else if (kind == K_RSEL) begin
                st_d.addr = st_q.addr & ~COL_MASK;
                st_d.cnt  = '0;
            end else begin
                st_d.cmd = (kind == K_RD1 || kind == K_RD2) ? OPC_RD0 : io_din;
                if (kind != K_RGO) st_d.cnt = '0;
                b_clr = 1'b1;
                case (kind)
                    K_RD0: st_d.ofs = '0;
                    K_RD1: st_d.ofs = OFS_W'(16'h0100);
                    K_RD2: st_d.ofs = PAGE_SIZE;
                    K_STAT: begin
                        b_ld    = 1'b1;
                        b_data  = {24'h0, wp_n, 1'b0, 5'b0, st_q.fail};
                        b_len   = LW'(1);
                        b_stick = 1'b1;
                    end
                    K_PGO: begin
                        st_d.pg   = wp_n;
                        st_d.fail = !wp_n;
                    end
                    K_EGO: begin
                        st_d.addr = st_q.addr << COL_BITS;
                        st_d.er   = wp_n;
                        st_d.fail = !wp_n;
                    end
                    K_RGO: begin
                        st_d.ld  = 1'b1;
                        st_d.col = OFS_W'(st_q.addr & COL_MASK);
                    end
                    K_RST: begin
                        st_d.cmd  = OPC_RD0;
                        st_d.addr = '0;
                        st_d.cnt  = '0;
                        st_d.ofs  = '0;
                        st_d.fail = 1'b0;
                    end
                    default: ;
                endcase
            end
        end else if (adr_cyc) begin
            if (st_q.cnt < CNT_W'(ADDR_BYTES)) begin
                for (int i = 0; i < ADDR_BYTES; i++) begin
                    if (st_q.cnt == CNT_W'(i)) st_d.addr[8*i +: 8] = io_din;
                end
                st_d.cnt = cnt_inc;
                if (cnt_inc == CNT_W'(1) && st_q.cmd == OPC_ID) begin
                    b_ld   = 1'b1;
                    b_data = {ID_LAST, ID_FILLER, DEV_ID, MFR_ID};
                    b_len  = LW'(BUF_BYTES);
                end
                if (cnt_inc == CNT_W'(TRIG_CYC)) begin
                    if (st_q.cmd == OPC_RD0) begin
                        st_d.ld  = 1'b1;
                        st_d.col = st_q.ofs;
                    end
                    if (st_q.cmd == OPC_PSET) st_d.su = 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    nand_outbuf #(.DEPTH(BUF_BYTES)) u_obuf (
        .clk      (clk),
        .rst_n    (rst_n),
        .ld       (b_ld),
        .clr      (b_clr),
        .rd       (io_re && !ce_n),
        .ld_data  (b_data),
        .ld_len   (b_len),
        .ld_stick (b_stick),
        .dout     (io_dout)
    );

    assign load_go  = st_q.ld;
    assign setup_go = st_q.su;
    assign prog_go  = st_q.pg;
    assign erase_go = st_q.er;
    assign cmd_err  = st_q.bad;
    assign op_addr  = st_q.addr;
    assign op_col   = st_q.col;

    // R12
    pulse_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({load_go, setup_go, prog_go, erase_go, cmd_err}));

    // R9
    prot_guard_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (prog_go || erase_go) |-> $past(wp_n));

    // R11
    bad_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_err |-> (op_addr == $past(op_addr) && st_q.cmd == $past(st_q.cmd)));

    // R4
    cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt <= CNT_W'(ADDR_BYTES));

endmodule

// File: tb/nand_cmd_front_tb.sv
module nand_cmd_front_tb_top;

    localparam int NI = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ce_n = 1'b0, cle = 1'b0, ale = 1'b0, wp_n = 1'b1;
    logic io_we = 1'b0, io_re = 1'b0;
    logic [7:0] din = 8'h00;

    logic [7:0]  dout_w [NI];
    logic        ld_w [NI], su_w [NI], pg_w [NI], er_w [NI], bad_w [NI];
    logic [39:0] addr_w [NI];
    logic [15:0] col_w [NI];

    int n_chk = 0;
    int n_err = 0;

    always #10 clk = ~clk;

    nand_cmd_front dut_i (
        .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .cle(cle), .ale(ale), .wp_n(wp_n),
        .io_we(io_we), .io_re(io_re), .io_din(din), .io_dout(dout_w[0]),
        .load_go(ld_w[0]), .setup_go(su_w[0]), .prog_go(pg_w[0]), .erase_go(er_w[0]),
        .cmd_err(bad_w[0]), .op_addr(addr_w[0]), .op_col(col_w[0]));

    nand_cmd_front #(.LARGE_PAGE(1'b1), .DENSITY_MBIT(1024)) dut_m_i (
        .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .cle(cle), .ale(ale), .wp_n(wp_n),
        .io_we(io_we), .io_re(io_re), .io_din(din), .io_dout(dout_w[1]),
        .load_go(ld_w[1]), .setup_go(su_w[1]), .prog_go(pg_w[1]), .erase_go(er_w[1]),
        .cmd_err(bad_w[1]), .op_addr(addr_w[1]), .op_col(col_w[1]));

    nand_cmd_front #(.LARGE_PAGE(1'b1), .DENSITY_MBIT(2048)) dut_l_i (
        .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .cle(cle), .ale(ale), .wp_n(wp_n),
        .io_we(io_we), .io_re(io_re), .io_din(din), .io_dout(dout_w[2]),
        .load_go(ld_w[2]), .setup_go(su_w[2]), .prog_go(pg_w[2]), .erase_go(er_w[2]),
        .cmd_err(bad_w[2]), .op_addr(addr_w[2]), .op_col(col_w[2]));

    // ---------------- reference model ----------------
    int          mcmd [NI];
    logic [39:0] maddr [NI];
    int          mcnt [NI];
    int          mofs [NI];
    bit          merr [NI];
    int          mcol [NI];
    logic [7:0]  mq [NI][$];
    bit          mstk [NI];
    bit          e_ld [NI], e_su [NI], e_pg [NI], e_er [NI], e_bad [NI];

    function automatic bit f_lp(int k);   return k > 0; endfunction
    function automatic int f_trig(int k); return (k == 0) ? 3 : ((k == 1) ? 4 : 5); endfunction
    function automatic int f_colb(int k); return (k == 0) ? 8 : 16; endfunction
    function automatic int f_pgsz(int k); return (k == 0) ? 512 : 2048; endfunction

    function automatic void model_cmd(int k, logic [7:0] b);
        bit known;
        known = (b inside {8'h00, 8'h01, 8'h50, 8'h90, 8'hFF, 8'h80, 8'h10,
                           8'h60, 8'hD0, 8'h70, 8'h85})
             || (f_lp(k) && (b inside {8'h30, 8'h05, 8'hE0}));
        if (!known) begin e_bad[k] = 1; return; end
        if (f_lp(k) && b == 8'h30 && mcmd[k] == 0) return;
        if (f_lp(k) && b == 8'h05) begin
            maddr[k] = maddr[k] & ~((40'd1 << f_colb(k)) - 40'd1);
            mcnt[k]  = 0;
            return;
        end
        if (b == 8'h00) mofs[k] = 0;
        if (b == 8'h01) mofs[k] = 256;
        if (b == 8'h50) mofs[k] = f_pgsz(k);
        mcmd[k] = (b == 8'h01 || b == 8'h50) ? 0 : int'(b);
        if (b != 8'hE0) mcnt[k] = 0;
        mq[k].delete();
        mstk[k] = 0;
        case (b)
            8'h70: begin mq[k].push_back({wp_n, 6'b0, merr[k]}); mstk[k] = 1; end
            8'h10: begin if (wp_n) begin e_pg[k] = 1; merr[k] = 0; end else merr[k] = 1; end
            8'hD0: begin
                maddr[k] = maddr[k] << f_colb(k);
                if (wp_n) begin e_er[k] = 1; merr[k] = 0; end else merr[k] = 1;
            end
            8'hE0: begin e_ld[k] = 1; mcol[k] = int'(maddr[k][15:0]); end
            8'hFF: begin mcmd[k] = 0; maddr[k] = 0; mcnt[k] = 0; mofs[k] = 0; merr[k] = 0; end
            default: ;
        endcase
    endfunction

    function automatic void model_addr(int k, logic [7:0] b);
        if (mcnt[k] >= 5) return;
        maddr[k][8*mcnt[k] +: 8] = b;
        mcnt[k]++;
        if (mcnt[k] == 1 && mcmd[k] == 'h90) begin
            mq[k].push_back(8'hEC);
            mq[k].push_back(8'h73);
            mq[k].push_back(8'hA5);
            mq[k].push_back(f_lp(k) ? 8'h15 : 8'hC0);
        end
        if (mcnt[k] == f_trig(k)) begin
            if (mcmd[k] == 0) begin e_ld[k] = 1; mcol[k] = mofs[k]; end
            if (mcmd[k] == 'h80) e_su[k] = 1;
        end
    endfunction

    always @(posedge clk) begin
        for (int k = 0; k < NI; k++) begin
            e_ld[k] = 0; e_su[k] = 0; e_pg[k] = 0; e_er[k] = 0; e_bad[k] = 0;
            if (!rst_n) begin
                mcmd[k] = 0; maddr[k] = 0; mcnt[k] = 0; mofs[k] = 0;
                merr[k] = 0; mcol[k] = 0; mq[k].delete(); mstk[k] = 0;
            end else begin
                if (io_we && !ce_n && cle)       model_cmd(k, din);
                else if (io_we && !ce_n && ale)  model_addr(k, din);
                if (io_re && !ce_n && mq[k].size() > 0 && !mstk[k]) void'(mq[k].pop_front());
            end
        end
    end

    // ---------------- checking ----------------
    function automatic void chk(string req, string what, longint act, longint exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endfunction

    always @(negedge clk) begin
        if (rst_n) begin
            for (int k = 0; k < NI; k++) begin
                chk("R6",  $sformatf("inst%0d load_go", k),  ld_w[k],  e_ld[k]);
                chk("R6",  $sformatf("inst%0d setup_go", k), su_w[k],  e_su[k]);
                chk("R9",  $sformatf("inst%0d prog_go", k),  pg_w[k],  e_pg[k]);
                chk("R9",  $sformatf("inst%0d erase_go", k), er_w[k],  e_er[k]);
                chk("R11", $sformatf("inst%0d cmd_err", k),  bad_w[k], e_bad[k]);
                chk("R4",  $sformatf("inst%0d op_addr", k),  addr_w[k], maddr[k]);
                chk("R3",  $sformatf("inst%0d op_col", k),   col_w[k],  mcol[k]);
                chk("R7",  $sformatf("inst%0d io_dout", k),  dout_w[k],
                    (mq[k].size() > 0) ? mq[k][0] : 8'h00);
                chk("R12", $sformatf("inst%0d pulse count", k),
                    ld_w[k] + su_w[k] + pg_w[k] + er_w[k] + bad_w[k] <= 1, 1);
            end
        end
    end

    task automatic step(bit c_ce_n, bit c_cle, bit c_ale, bit c_we, bit c_re, logic [7:0] d);
        ce_n = c_ce_n; cle = c_cle; ale = c_ale; io_we = c_we; io_re = c_re; din = d;
        @(negedge clk);
        ce_n = 1'b0; cle = 1'b0; ale = 1'b0; io_we = 1'b0; io_re = 1'b0;
    endtask

    task automatic cmd(logic [7:0] b); step(0, 1, 0, 1, 0, b); endtask
    task automatic adr(logic [7:0] b); step(0, 0, 1, 1, 0, b); endtask
    task automatic rdb();              step(0, 0, 0, 0, 1, 8'h00); endtask

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    endtask

    initial begin
        #(20 * 100000);
        n_err++;
        $display("FAIL watchdog: actual=hung expected=done");
        summary();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        for (int k = 0; k < NI; k++) begin
            chk("R1", "reset io_dout", dout_w[k], 8'h00);
            chk("R1", "reset op_addr", addr_w[k], 40'h0);
            chk("R1", "reset op_col", col_w[k], 16'h0);
            chk("R1", "reset pulses", {ld_w[k], su_w[k], pg_w[k], er_w[k], bad_w[k]}, 5'b0);
        end

        // R5 identification bytes
        cmd(8'h90); adr(8'h00);
        for (int k = 0; k < NI; k++) chk("R5", "id byte0", dout_w[k], 8'hEC);
        rdb();
        for (int k = 0; k < NI; k++) chk("R5", "id byte1", dout_w[k], 8'h73);
        rdb();
        for (int k = 0; k < NI; k++) chk("R5", "id byte2", dout_w[k], 8'hA5);
        rdb();
        chk("R5", "id byte3 small", dout_w[0], 8'hC0);
        chk("R5", "id byte3 large", dout_w[2], 8'h15);
        rdb();
        for (int k = 0; k < NI; k++) chk("R5", "id drained", dout_w[k], 8'h00);

        // R6 / R4 trigger points and address assembly
        cmd(8'h00); adr(8'h11); adr(8'h22); adr(8'h33);
        chk("R6", "small load at byte 3", ld_w[0], 1);
        chk("R6", "1G no load at byte 3", ld_w[1], 0);
        adr(8'h44);
        chk("R6", "1G load at byte 4", ld_w[1], 1);
        chk("R6", "2G no load at byte 4", ld_w[2], 0);
        adr(8'h55);
        chk("R6", "2G load at byte 5", ld_w[2], 1);
        for (int k = 0; k < NI; k++) chk("R4", "assembled address", addr_w[k], 40'h5544332211);

        // R3 offsets
        cmd(8'h01); adr(8'h01); adr(8'h02); adr(8'h03); adr(8'h04); adr(8'h05);
        for (int k = 0; k < NI; k++) chk("R3", "READ1 offset", col_w[k], 16'h0100);
        cmd(8'h50); adr(8'h01); adr(8'h02); adr(8'h03); adr(8'h04); adr(8'h05);
        chk("R3", "READ2 offset small", col_w[0], 16'd512);
        chk("R3", "READ2 offset large", col_w[2], 16'd2048);

        // R2 gating
        step(1, 1, 0, 1, 0, 8'hFF);
        step(0, 1, 0, 0, 0, 8'hFF);
        step(1, 0, 1, 1, 0, 8'h77);
        for (int k = 0; k < NI; k++) chk("R2", "ignored bytes keep address", addr_w[k], 40'h0504030201);

        // R7 sticky status
        wp_n = 1'b1;
        cmd(8'h70);
        for (int k = 0; k < NI; k++) chk("R7", "status byte", dout_w[k], 8'h80);
        rdb(); rdb();
        for (int k = 0; k < NI; k++) chk("R7", "status after reads", dout_w[k], 8'h80);
        cmd(8'h00);
        for (int k = 0; k < NI; k++) chk("R7", "status dropped by new command", dout_w[k], 8'h00);

        // R9 write protect on program
        wp_n = 1'b0;
        cmd(8'h80); adr(8'h00); adr(8'h00); adr(8'h10);
        chk("R6", "small setup at byte 3", su_w[0], 1);
        adr(8'h00); adr(8'h00);
        cmd(8'h10);
        for (int k = 0; k < NI; k++) chk("R9", "protected program blocked", pg_w[k], 0);
        cmd(8'h70);
        for (int k = 0; k < NI; k++) chk("R9", "error bit set", dout_w[k], 8'h01);
        wp_n = 1'b1;
        cmd(8'h10);
        for (int k = 0; k < NI; k++) chk("R9", "program starts", pg_w[k], 1);
        cmd(8'h70);
        for (int k = 0; k < NI; k++) chk("R9", "error bit cleared", dout_w[k], 8'h80);

        // R8 reset command
        wp_n = 1'b0; cmd(8'h10); wp_n = 1'b1;
        cmd(8'hFF);
        for (int k = 0; k < NI; k++) chk("R8", "reset clears address", addr_w[k], 40'h0);
        cmd(8'h70);
        for (int k = 0; k < NI; k++) chk("R8", "reset clears error bit", dout_w[k], 8'h80);

        // R9 erase with shift
        cmd(8'h60); adr(8'hAB); adr(8'hCD); adr(8'hEF); cmd(8'hD0);
        for (int k = 0; k < NI; k++) chk("R9", "erase starts", er_w[k], 1);
        chk("R9", "erase shift small", addr_w[0], 40'h00EFCDAB00);
        chk("R9", "erase shift large", addr_w[1], 40'hEFCDAB0000);

        // R10 large-page random read
        cmd(8'hFF);
        cmd(8'h00); adr(8'h01); adr(8'h02); adr(8'h03); adr(8'h04); adr(8'h05);
        cmd(8'h30);
        chk("R10", "0x30 unknown on small", bad_w[0], 1);
        chk("R10", "0x30 ignored on large", bad_w[1], 0);
        cmd(8'h05);
        chk("R10", "0x05 clears column", addr_w[1], 40'h0504030000);
        adr(8'h34); adr(8'h12); cmd(8'hE0);
        chk("R10", "random read load 1G", ld_w[1], 1);
        chk("R10", "random read load 2G", ld_w[2], 1);
        chk("R10", "random read column", col_w[2], 16'h1234);
        chk("R10", "0xE0 unknown on small", bad_w[0], 1);
        chk("R10", "small address untouched", addr_w[0], 40'h0504030201);

        // R11 unknown command
        cmd(8'h35);
        for (int k = 0; k < NI; k++) chk("R11", "unknown flagged", bad_w[k], 1);
        chk("R11", "unknown keeps address", addr_w[1], 40'h0504031234);
        cmd(8'h15);
        for (int k = 0; k < NI; k++) chk("R11", "cache confirm unknown", bad_w[k], 1);

        // R4 overflow and R2 command-over-address priority
        cmd(8'hFF);
        cmd(8'h00);
        for (int i = 0; i < 7; i++) adr(8'hA0 + 8'(i));
        for (int k = 0; k < NI; k++) chk("R4", "extra bytes dropped", addr_w[k], 40'hA4A3A2A1A0);
        step(0, 1, 1, 1, 0, 8'h90);
        adr(8'h00);
        for (int k = 0; k < NI; k++) chk("R2", "cle wins over ale", dout_w[k], 8'hEC);

        repeat (3) @(negedge clk);
        summary();
    end

endmodule